// File: doc/BRIEF.md
# Byte-wide fuse array read sequencer

This block reads bytes out of a one-time-programmable fuse macro that has a random-access read port: 32 rows of 8 bits behind a 10-bit address. A requester pulses a start input with a first byte address and a byte count. The block then drives the macro's 16-bit control word through a fixed sequence for every byte, and hands each data byte out on a valid/ready stream.

The sequence opens with a load phase that selects the chip. Each byte then gets its own steps: the address field is cleared for one cycle, the new address is written, strobe is raised after a settle interval, the data is captured, and strobe is dropped. The address advances by one for each byte. When the last byte is done, the macro goes back to a deselected standby. Every settle interval lasts a whole number of clock cycles, set by a parameter and timed by a down-counter. Requests that arrive while the block is busy are dropped.

Top module: `fuse_rd_seq`

## Requirements
- R1: While reset is high and right after it, `fuse_ctrl` is 16'h0009 (standby), `busy` is 0 and `out_valid` is 0.
- R2: A start seen while idle with a nonzero count makes `busy` high in the next cycle. `fuse_ctrl` then reads 16'h000C (load and program-disable high, chip-select low, address 0) for SETTLE_CYC cycles of load settle plus one address-clear cycle.
- R3: Each byte after the first begins with one cycle of 16'h000C (address field cleared). Every byte then holds its address in bits [15:6], with strobe low, for SETTLE_CYC cycles.
- R4: Strobe (bit 1) is then high for SETTLE_CYC cycles with `out_valid` low. `out_valid` rises next, with `out_data` equal to the macro output at the end of that interval, and strobe stays high while `out_valid` is high.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R6: The cycle after a byte is accepted, strobe drops and the address stays in place for SETTLE_CYC cycles.
- R7: Byte k of a request uses address (start + k) modulo 1024, and exactly `req_count` bytes are returned.
- R8: After the final settle of the last byte, `fuse_ctrl` returns to 16'h0009 and `busy` falls.
- R9: A start while busy, or a start with count 0, has no effect on `fuse_ctrl`, `busy` or the bytes returned.
- R10: Control word layout: bit 0 chip-select (low = selected), bit 1 strobe, bit 2 load, bit 3 program-disable, bits [5:4] zero, bits [15:6] fuse address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse for a read request |
| req_addr | input | 10 | First byte address |
| req_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | High while a request is in progress |
| fuse_ctrl | output | 16 | Control word to the fuse macro |
| fuse_dout | input | 8 | Data output of the fuse macro |
| out_valid | output | 1 | Byte available on out_data |
| out_data | output | 8 | Byte read from the array |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
Random requests with random start addresses, random counts and random back-pressure are checked cycle by cycle against a control-word trace computed in the bench. Any error in phase length or phase order shows up at the cycle where it occurs. A start address near 1023 separates correct 10-bit wrap from an overflow into the control bits. The fuse model drives zero whenever strobe is low, so a capture taken at the wrong time is seen as a data error. Count-zero requests and starts injected during the load phase check that ignored requests really have no effect.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int FA_W   = 10;
  localparam int FA_LSB = 6;
  localparam int CTRL_W = 16;
  localparam int B_CSB  = 0;
  localparam int B_STRB = 1;
  localparam int B_LOAD = 2;
  localparam int B_PGEN = 3;

  typedef enum logic [2:0] {
    S_STBY, S_LOADW, S_ACLR, S_ASET, S_STRB, S_CAPT, S_SDROP
  } seq_st_t;

  function automatic logic [CTRL_W-1:0] ctrl_pack(input logic csb, input logic strb,
                                                  input logic load, input logic pgen,
                                                  input logic [FA_W-1:0] a);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[FA_LSB +: FA_W] = a;
    w[B_CSB]  = csb;
    w[B_STRB] = strb;
    w[B_LOAD] = load;
    w[B_PGEN] = pgen;
    return w;
  endfunction

  function automatic logic [FA_W-1:0] next_addr(input logic [FA_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/fuse_settle_timer.sv
module fuse_settle_timer #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int TW = $clog2(SETTLE_CYC + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= TW'(SETTLE_CYC - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R6: every settle interval counts down one step per cycle
  assert_settle_countdown_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fuse_byte_tracker.sv
module fuse_byte_tracker
  import fuse_rd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [FA_W-1:0]  start_addr,
  input  logic [CNT_W-1:0] start_cnt,
  output logic [FA_W-1:0]  cur_addr,
  output logic             last
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      left     <= '0;
    end else if (load) begin
      cur_addr <= start_addr;
      left     <= start_cnt;
    end else if (step) begin
      cur_addr <= next_addr(cur_addr);
      left     <= left - 1'b1;
    end
  end

  assign last = (left == CNT_W'(1));

  // R9: without a load or step, position and remaining count stay put
  assert_tracker_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(cur_addr) && $stable(left)));
  // R7: a step advances the address by one
  assert_step_inc_R7: assert property (@(posedge clk) disable iff (rst)
    step |=> (cur_addr == FA_W'($past(cur_addr) + 1)));
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic [9:0]       req_addr,
  input  logic [CNT_W-1:0] req_count,
  output logic             busy,
  output logic [15:0]      fuse_ctrl,
  input  logic [7:0]       fuse_dout,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready
);
  seq_st_t state, nxt;
  logic tmr_load, tmr_exp;
  logic trk_load, trk_step, trk_last;
  logic [FA_W-1:0] cur_addr;
  logic accept, handoff, capture;

  assign accept  = req_start && (state == S_STBY) && (req_count != '0);
  assign handoff = out_valid && out_ready;
  assign capture = (state == S_STRB) && tmr_exp;

  fuse_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .expired(tmr_exp)
  );

  fuse_byte_tracker #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .load(trk_load), .step(trk_step),
    .start_addr(req_addr), .start_cnt(req_count),
    .cur_addr(cur_addr), .last(trk_last)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    trk_load = 1'b0;
    trk_step = 1'b0;
    case (state)
      S_STBY:  if (accept) begin nxt = S_LOADW; tmr_load = 1'b1; trk_load = 1'b1; end
      S_LOADW: if (tmr_exp) nxt = S_ACLR;
      S_ACLR:  begin nxt = S_ASET; tmr_load = 1'b1; end
      S_ASET:  if (tmr_exp) begin nxt = S_STRB; tmr_load = 1'b1; end
      S_STRB:  if (tmr_exp) nxt = S_CAPT;
      S_CAPT:  if (handoff) begin nxt = S_SDROP; tmr_load = 1'b1; end
      S_SDROP: if (tmr_exp) begin
                 if (trk_last) nxt = S_STBY;
                 else begin nxt = S_ACLR; trk_step = 1'b1; end
               end
      default: nxt = S_STBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_STBY;
    else     state <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (capture) begin
      out_valid <= 1'b1;
      out_data  <= fuse_dout;
    end else if (handoff) begin
      out_valid <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      S_LOADW, S_ACLR: fuse_ctrl = ctrl_pack(1'b0, 1'b0, 1'b1, 1'b1, '0);
      S_ASET, S_SDROP: fuse_ctrl = ctrl_pack(1'b0, 1'b0, 1'b1, 1'b1, cur_addr);
      S_STRB, S_CAPT:  fuse_ctrl = ctrl_pack(1'b0, 1'b1, 1'b1, 1'b1, cur_addr);
      default:         fuse_ctrl = ctrl_pack(1'b1, 1'b0, 1'b0, 1'b1, '0);
    endcase
  end

  assign busy = (state != S_STBY);

  // R5: an offered byte waits, unchanged, for the consumer
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R4: strobe stays high and the chip selected while a byte is offered
  assert_valid_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fuse_ctrl[B_STRB] && !fuse_ctrl[B_CSB]));
  // R3: the address is already in place when strobe rises
  assert_addr_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fuse_ctrl[B_STRB]) |-> (fuse_ctrl[FA_LSB +: FA_W] == $past(fuse_ctrl[FA_LSB +: FA_W])));
  // R8: leaving a request always lands on standby
  assert_standby_exit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (fuse_ctrl == 16'h0009 && !out_valid));
  // R2: a request only starts from a start pulse
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_start));
endmodule

// File: tb/fuse_rd_seq_tb.sv
module fuse_rd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int CNT_W      = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 1'b0;
  logic [9:0] req_addr = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic busy, out_valid, out_ready = 1'b0;
  logic [15:0] fuse_ctrl;
  logic [7:0] fuse_dout, out_data;
  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_rd_seq #(.SETTLE_CYC(SETTLE), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_count(req_count), .busy(busy), .fuse_ctrl(fuse_ctrl),
    .fuse_dout(fuse_dout), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  // fuse array model: 32 rows, content computed, zero output unless strobed and selected
  function automatic logic [7:0] fuse_byte(input logic [9:0] a);
    logic [4:0] r;
    r = a[4:0];
    return (8'(r) * 8'd29 + 8'd7) ^ {r[2:0], r};
  endfunction
  assign fuse_dout = (fuse_ctrl[1] && !fuse_ctrl[0]) ? fuse_byte(fuse_ctrl[15:6]) : 8'h00;

  // R10 layout: addr [15:6], program-disable 3, load 2, strobe 1, chip-select 0
  function automatic logic [15:0] sel_word(input logic strobe, input logic [9:0] a);
    return {a, 2'b00, 1'b1, 1'b1, strobe, 1'b0};
  endfunction

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk(fuse_ctrl, 16'h0009, {tag, " ctrl"});
    chk(16'(busy), 16'd0, {tag, " busy"});
    chk(16'(out_valid), 16'd0, {tag, " valid"});
  endtask

  task automatic run_req(input logic [9:0] a0, input int cnt, input bit poke);
    @(negedge clk);
    req_start = 1'b1; req_addr = a0; req_count = CNT_W'(cnt);
    for (int i = 0; i < SETTLE + 1; i++) begin
      @(negedge clk);
      chk(fuse_ctrl, sel_word(1'b0, '0), "R2 load phase");
      chk(16'(busy), 16'd1, "R2 busy");
      req_start = poke && (i == 0);
      req_addr = ~a0; req_count = CNT_W'(cnt + 2);
    end
    req_start = 1'b0;
    for (int b = 0; b < cnt; b++) begin
      logic [9:0] a;
      int waits;
      a = 10'(a0 + 10'(b));
      if (b > 0) begin
        @(negedge clk);
        chk(fuse_ctrl, sel_word(1'b0, '0), "R3 addr clear");
      end
      for (int i = 0; i < SETTLE; i++) begin
        @(negedge clk);
        chk(fuse_ctrl, sel_word(1'b0, a), "R3 R7 R10 addr set");
      end
      for (int i = 0; i < SETTLE; i++) begin
        @(negedge clk);
        chk(fuse_ctrl, sel_word(1'b1, a), "R4 strobe");
        chk(16'(out_valid), 16'd0, "R4 early valid");
      end
      waits = 0;
      forever begin
        @(negedge clk);
        chk(fuse_ctrl, sel_word(1'b1, a), "R4 strobe hold");
        chk(16'(out_valid), 16'd1, "R5 valid");
        chk(16'(out_data), 16'(fuse_byte(a)), "R4 R7 data");
        out_ready = ($urandom % 3 == 0) || (waits >= 4);
        waits++;
        if (out_ready) break;
      end
      for (int i = 0; i < SETTLE; i++) begin
        @(negedge clk);
        out_ready = 1'b0;
        chk(fuse_ctrl, sel_word(1'b0, a), "R6 strobe low");
        chk(16'(out_valid), 16'd0, "R6 valid");
      end
    end
    @(negedge clk);
    idle_chk("R8 standby");
    @(negedge clk);
    idle_chk("R9 no restart");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    idle_chk("R1 after reset");
    // R9: count of zero is dropped
    req_start = 1'b1; req_addr = 10'd5; req_count = '0;
    @(negedge clk);
    req_start = 1'b0;
    idle_chk("R9 zero count");
    @(negedge clk);
    idle_chk("R9 zero count later");
    // directed: single byte, multi byte, wrap at top of address field, start while busy
    run_req(10'd0, 1, 1'b0);
    run_req(10'd30, 5, 1'b0);
    run_req(10'd1022, 4, 1'b1);
    run_req(10'd7, 3, 1'b1);
    for (int t = 0; t < 30; t++) begin
      run_req(10'($urandom), 1 + int'($urandom % 6), bit'($urandom % 2));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule